// File: doc/BRIEF.md
# Table-Based Audio Stimulus Generator

This block produces the sample stream for an auditory test stimulus. Its output is signed 32-bit samples, and those samples go on to a codec serializer. The serializer sets the pace with a one-cycle sample strobe. For each strobe that arrives during a run, the block presents one sample together with a one-cycle valid pulse.

The block has two stimulus modes, selected when a run starts:

- **Pure tone.** The block walks a 48-entry, one-period sine table held on chip. Each entry is repeated for a programmable number of strobes, so the tone frequency is the sample rate divided by 48 times that count.
- **Click.** The block gives a square-wave beep that alternates between one second of tone and one second of silence.

A start pulse opens a run. The run closes by itself after ten seconds, or at once on an abort. The length of one second is a parameter counted in clock cycles, so a short run can be used in test.

Top module: `audio_stim_gen`

## Requirements
- R1: While reset (active low) is held, and right after it, `busy`, `sample_vld` and `sample_out` are all zero.
- R2: A `start` pulse seen while idle, with `abort` low, raises `busy` on the next clock. On that edge the mode (`mode_sel` 0 = tone, 1 = click) and `tone_ivl` are captured; a captured interval of 0 acts as 1.
- R3: Without an abort, `busy` stays high for exactly `RUN_SECS*SEC_CYC` clocks and then falls by itself.
- R4: Each clock with `smp_tick` high, `busy` high and `abort` low gives `sample_vld` high for one clock on the next edge. `sample_vld` is low at all other times.
- R5: In tone mode, the k-th sample of a run (k from 0) is table entry (k / ivl) mod 48, using integer division. For i < 24, entry i is floor(TONE_AMP*16p/(2880-4p)) with p = i*(24-i). Entry i+24 is the negative of entry i. So entries 0 and 24 are zero, and entry 12 equals TONE_AMP.
- R6: In click mode, a sample emitted during run cycle e (counted from 0 at the first busy cycle) is zero when floor(e/SEC_CYC) is odd. Otherwise the k-th sample of the run is +CLICK_AMP when floor(k/CLICK_HALF) is even, and -CLICK_AMP when it is odd.
- R7: `sample_out` is exactly zero whenever `sample_vld` is low.
- R8: A `start` pulse while `busy` is high is ignored: neither the run length nor the sample sequence changes.
- R9: Changing `tone_ivl` or `mode_sel` during a run has no effect on that run.
- R10: `abort` while busy drops `busy` on the next clock, and no sample is emitted for that clock. `abort` together with `start` while idle leaves the block idle.
- R11: Samples are 32-bit two's complement. With the default tone amplitude, the values +(2^31-1) and -(2^31-1) are both emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_tick | input | 1 | One-cycle sample-rate strobe |
| mode_sel | input | 1 | 0 = pure tone, 1 = click; captured at start |
| tone_ivl | input | IVL_W | Strobes per sine-table entry; captured at start |
| start | input | 1 | Start pulse |
| abort | input | 1 | Stop the current run immediately |
| sample_out | output | SMP_W | Signed sample value |
| sample_vld | output | 1 | Sample valid, one cycle per strobe during a run |
| busy | output | 1 | Run in progress |

## Verification
The hardest cases to reach are the coincidences:

- a strobe arriving on the abort cycle;
- a strobe arriving on the last busy cycle;
- a silent/on boundary falling between two strobes.

These only show up when the strobe pattern, the phase timing and the control pulses line up. The bench shortens one second to 40 clocks. It then drives the strobe every cycle, every fourth cycle, and on a pseudo-random pattern. Start, abort and interval changes are placed inside runs.

A behavioural model built on elapsed-cycle and sample counts predicts every output on every clock. Because the model tracks counts rather than the design's state, any misplaced edge at these boundaries shows up as a mismatch.

// File: rtl/audio_stim_pkg.sv
// Shared definitions for the audio stimulus generator.
// Assumes the table length is even; the table is half a period plus its negation.
package audio_stim_pkg;

    typedef enum logic {
        MODE_TONE  = 1'b0,
        MODE_CLICK = 1'b1
    } stim_mode_e;

    // Integer sine approximation for entry idx of a len-entry period, scaled by amp.
    // Uses a rational half-wave fit that is exact at 0, 90 and 180 degrees.
    function automatic longint sine_entry(input int idx, input int len, input longint amp);
        int     half;
        int     k;
        longint p;
        longint v;
        half = len / 2;
        k    = (idx < half) ? idx : idx - half;
        p    = longint'(k * (half - k));
        v    = (amp * 64'sd16 * p) / (longint'(5 * half * half) - 64'sd4 * p);
        return (idx < half) ? v : -v;
    endfunction

endpackage

// File: rtl/stim_timer.sv
// Run timer: holds busy for RUN_SECS periods of SEC_CYC clocks and reports
// whether the current period is odd-numbered (the silent half of a click).
// Assumes launch is only asserted while idle; halt wins over expiry.
module stim_timer #(
    parameter int SEC_CYC  = 125_000_000,
    parameter int RUN_SECS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic halt,
    output logic busy,
    output logic silent
);
    localparam int SEC_W = $clog2(SEC_CYC + 1);
    localparam int NUM_W = $clog2(RUN_SECS + 1);

    logic [SEC_W-1:0] sec_cnt;
    logic [NUM_W-1:0] sec_num;

    // Count clocks within a period and periods within a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sec_cnt <= '0;
            sec_num <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy    <= 1'b1;
                sec_cnt <= '0;
                sec_num <= '0;
            end
        end else if (halt) begin
            busy <= 1'b0;
        end else if (sec_cnt == SEC_W'(SEC_CYC - 1)) begin
            sec_cnt <= '0;
            if (sec_num == NUM_W'(RUN_SECS - 1)) begin
                busy <= 1'b0;
            end else begin
                sec_num <= sec_num + 1'b1;
            end
        end else begin
            sec_cnt <= sec_cnt + 1'b1;
        end
    end

    assign silent = sec_num[0];
endmodule

// File: rtl/tone_stepper.sv
// Sine-table walker: repeats each table entry for the captured interval of
// emitted samples, then moves to the next entry, wrapping at the table end.
// Assumes adv is only asserted while a run is active.
module tone_stepper
    import audio_stim_pkg::*;
#(
    parameter int     TABLE_LEN = 48,
    parameter int     IVL_W     = 16,
    parameter int     SMP_W     = 32,
    parameter longint TONE_AMP  = 64'd2147483647
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic [IVL_W-1:0]        ivl_in,
    input  logic                    adv,
    output logic signed [SMP_W-1:0] tone_smp
);
    localparam int ADDR_W = $clog2(TABLE_LEN);

    logic signed [SMP_W-1:0] rom [TABLE_LEN];
    logic [ADDR_W-1:0]       addr;
    logic [IVL_W-1:0]        step;
    logic [IVL_W-1:0]        ivl_q;

    // Fill the table from the package formula, one entry per generate branch.
    for (genvar g = 0; g < TABLE_LEN; g++) begin : g_rom
        assign rom[g] = SMP_W'(sine_entry(g, TABLE_LEN, TONE_AMP));
    end

    // Capture the interval at launch; advance the table address per interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            step  <= '0;
            ivl_q <= IVL_W'(1);
        end else if (launch) begin
            addr  <= '0;
            step  <= '0;
            ivl_q <= (ivl_in == '0) ? IVL_W'(1) : ivl_in;
        end else if (adv) begin
            if (step == ivl_q - IVL_W'(1)) begin
                step <= '0;
                addr <= (addr == ADDR_W'(TABLE_LEN - 1)) ? '0 : addr + 1'b1;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    assign tone_smp = rom[addr];
endmodule

// File: rtl/click_gen.sv
// Click source: square wave between +CLICK_AMP and -CLICK_AMP, flipping every
// CLICK_HALF emitted samples, and forced to zero in the silent period.
// Assumes silent comes from the run timer and adv only occurs during a run.
module click_gen #(
    parameter int     CLICK_HALF = 24,
    parameter int     SMP_W      = 32,
    parameter longint CLICK_AMP  = 64'd1073741824
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic                    adv,
    input  logic                    silent,
    output logic signed [SMP_W-1:0] click_smp
);
    localparam int HALF_W = $clog2(CLICK_HALF + 1);
    localparam logic signed [SMP_W-1:0] POS = SMP_W'(CLICK_AMP);
    localparam logic signed [SMP_W-1:0] NEG = -POS;

    logic [HALF_W-1:0] cnt;
    logic              pol;

    // Count emitted samples and flip polarity each half cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            cnt <= '0;
            pol <= 1'b0;
        end else if (adv) begin
            if (cnt == HALF_W'(CLICK_HALF - 1)) begin
                cnt <= '0;
                pol <= ~pol;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign click_smp = silent ? '0 : (pol ? NEG : POS);
endmodule

// File: rtl/audio_stim_gen.sv
// Audio stimulus generator top: gates start and abort, captures the mode,
// and registers one sample with a valid pulse for each strobe during a run.
// Assumes smp_tick is a single-cycle strobe synchronous to clk.
module audio_stim_gen
    import audio_stim_pkg::*;
#(
    parameter int     SMP_W      = 32,
    parameter int     IVL_W      = 16,
    parameter int     TABLE_LEN  = 48,
    parameter int     SEC_CYC    = 125_000_000,
    parameter int     RUN_SECS   = 10,
    parameter int     CLICK_HALF = 24,
    parameter longint TONE_AMP   = 64'd2147483647,
    parameter longint CLICK_AMP  = 64'd1073741824
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_tick,
    input  logic                    mode_sel,
    input  logic [IVL_W-1:0]        tone_ivl,
    input  logic                    start,
    input  logic                    abort,
    output logic signed [SMP_W-1:0] sample_out,
    output logic                    sample_vld,
    output logic                    busy
);
    logic                    launch;
    logic                    adv;
    logic                    silent;
    stim_mode_e              mode_q;
    logic signed [SMP_W-1:0] tone_smp;
    logic signed [SMP_W-1:0] click_smp;

    assign launch = !busy && start && !abort;
    assign adv    = busy && smp_tick && !abort;

    stim_timer #(.SEC_CYC(SEC_CYC), .RUN_SECS(RUN_SECS)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .halt(abort),
        .busy(busy), .silent(silent)
    );

    tone_stepper #(.TABLE_LEN(TABLE_LEN), .IVL_W(IVL_W), .SMP_W(SMP_W),
                   .TONE_AMP(TONE_AMP)) u_tone (
        .clk(clk), .rst_n(rst_n), .launch(launch), .ivl_in(tone_ivl),
        .adv(adv), .tone_smp(tone_smp)
    );

    click_gen #(.CLICK_HALF(CLICK_HALF), .SMP_W(SMP_W),
                .CLICK_AMP(CLICK_AMP)) u_click (
        .clk(clk), .rst_n(rst_n), .launch(launch), .adv(adv),
        .silent(silent), .click_smp(click_smp)
    );

    // Capture the stimulus mode at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_TONE;
        end else if (launch) begin
            mode_q <= stim_mode_e'(mode_sel);
        end
    end

    // Register the selected sample on each accepted strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !adv) begin
            sample_vld <= 1'b0;
            sample_out <= '0;
        end else begin
            sample_vld <= 1'b1;
            sample_out <= (mode_q == MODE_CLICK) ? click_smp : tone_smp;
        end
    end
endmodule

// File: rtl/audio_stim_gen_chk.sv
// Property checker for audio_stim_gen, attached with bind below.
// Assumes the same timing parameters as the instance it is bound to.
module audio_stim_gen_chk #(
    parameter int SMP_W    = 32,
    parameter int SEC_CYC  = 125_000_000,
    parameter int RUN_SECS = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_tick,
    input logic                    start,
    input logic                    abort,
    input logic signed [SMP_W-1:0] sample_out,
    input logic                    sample_vld,
    input logic                    busy
);
    localparam logic [63:0] RUN_CYC = 64'(SEC_CYC) * 64'(RUN_SECS);

    logic [63:0] busy_len;

    // Count consecutive busy cycles to bound the run length.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= '0;
        else                 busy_len <= busy_len + 64'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !sample_vld));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !abort) |=> busy);

    assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < RUN_CYC));

    assert_vld_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> ($past(smp_tick) && $past(busy) && !$past(abort)));

    assert_vld_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && smp_tick && !abort) |=> sample_vld);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> (sample_out == '0));

    assert_abort_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && !sample_vld));

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && abort) |=> !busy);
endmodule

bind audio_stim_gen audio_stim_gen_chk #(
    .SMP_W(SMP_W), .SEC_CYC(SEC_CYC), .RUN_SECS(RUN_SECS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .start(start),
    .abort(abort), .sample_out(sample_out), .sample_vld(sample_vld),
    .busy(busy)
);

// File: tb/audio_stim_gen_tb.sv
`timescale 1ns/1ps
// Bench for audio_stim_gen: a behavioural model predicts every output on every clock.
module audio_stim_gen_tb;
    localparam int     SMP_W      = 32;
    localparam int     IVL_W      = 16;
    localparam int     SEC_CYC    = 40;
    localparam int     RUN_SECS   = 10;
    localparam int     RUN_CYC    = SEC_CYC * RUN_SECS;
    localparam int     CLICK_HALF = 3;
    localparam longint TONE_AMP   = 64'd2147483647;
    localparam longint CLICK_AMP  = 64'd1073741824;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_tick = 1'b0;
    logic                    mode_sel = 1'b0;
    logic [IVL_W-1:0]        tone_ivl = '0;
    logic                    start = 1'b0;
    logic                    abort = 1'b0;
    logic signed [SMP_W-1:0] sample_out;
    logic                    sample_vld;
    logic                    busy;

    int     checks = 0;
    int     fails = 0;
    int     tick_pat = 0;
    int     cyc = 0;
    bit     done = 1'b0;
    string  cur_req = "R1";
    bit     saw_pos_max = 1'b0;
    bit     saw_neg_max = 1'b0;

    // reference model state
    bit     m_busy = 1'b0;
    int     m_e = 0;
    int     m_n = 0;
    int     m_ivl = 1;
    int     m_mode = 0;
    bit     exp_vld = 1'b0;
    longint exp_out = 0;

    audio_stim_gen #(
        .SMP_W(SMP_W), .IVL_W(IVL_W), .TABLE_LEN(48), .SEC_CYC(SEC_CYC),
        .RUN_SECS(RUN_SECS), .CLICK_HALF(CLICK_HALF),
        .TONE_AMP(TONE_AMP), .CLICK_AMP(CLICK_AMP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .mode_sel(mode_sel),
        .tone_ivl(tone_ivl), .start(start), .abort(abort),
        .sample_out(sample_out), .sample_vld(sample_vld), .busy(busy)
    );

    always #4 clk = ~clk;

    function automatic longint table_val(input int i);
        longint p;
        longint v;
        int     k;
        k = i % 24;
        p = longint'(k * (24 - k));
        v = (TONE_AMP * 16 * p) / (2880 - 4 * p);
        return (i < 24) ? v : -v;
    endfunction

    function automatic longint model_val(input int e, input int n);
        if (m_mode == 1) begin
            if (((e / SEC_CYC) % 2) == 1) return 0;
            return (((n / CLICK_HALF) % 2) == 0) ? CLICK_AMP : -CLICK_AMP;
        end
        return table_val((n / m_ivl) % 48);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference updated at each rising edge from the stable inputs.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; exp_vld = 0; exp_out = 0;
        end else if (!m_busy) begin
            exp_vld = 0; exp_out = 0;
            if (start && !abort) begin
                m_busy = 1; m_e = 0; m_n = 0; m_mode = int'(mode_sel);
                m_ivl = (tone_ivl == 0) ? 1 : int'(tone_ivl);
            end
        end else if (abort) begin
            m_busy = 0; exp_vld = 0; exp_out = 0;
        end else begin
            if (smp_tick) begin
                exp_vld = 1; exp_out = model_val(m_e, m_n); m_n++;
            end else begin
                exp_vld = 0; exp_out = 0;
            end
            if (m_e == RUN_CYC - 1) m_busy = 0;
            else m_e++;
        end
    end

    // Compare every output on the falling edge; drive the strobe pattern.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_req, " busy"}, longint'(busy), longint'(m_busy));
            check({cur_req, " vld"}, longint'(sample_vld), longint'(exp_vld));
            check({cur_req, " sample"}, longint'(sample_out), exp_out);
            if (sample_vld && longint'(sample_out) == TONE_AMP) saw_pos_max = 1;
            if (sample_vld && longint'(sample_out) == -TONE_AMP) saw_neg_max = 1;
        end
        case (tick_pat)
            0: smp_tick <= 1'b1;
            1: smp_tick <= (cyc % 4) == 0;
            default: smp_tick <= ($urandom % 3) == 0;
        endcase
    end

    task automatic go(input bit md, input int ivl);
        @(negedge clk);
        mode_sel = md; tone_ivl = IVL_W'(ivl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int blen;
        repeat (3) @(negedge clk);
        check("R1 reset busy", longint'(busy), 0);
        check("R1 reset vld", longint'(sample_vld), 0);
        check("R1 reset sample", longint'(sample_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 / R11 / R3: tone, interval 1, strobe every cycle; measure run length
        cur_req = "R5"; tick_pat = 0;
        go(1'b0, 1);
        check("R2 busy after start", longint'(busy), 1);
        blen = 1;
        while (busy) begin @(negedge clk); if (busy) blen++; end
        check("R3 run length", longint'(blen), longint'(RUN_CYC));
        repeat (5) @(negedge clk);
        check("R11 full-scale positive seen", longint'(saw_pos_max), 1);
        check("R11 full-scale negative seen", longint'(saw_neg_max), 1);

        // R8 / R9: tone interval 3, strobe every 4th; restart and input changes mid-run
        cur_req = "R9"; tick_pat = 1;
        go(1'b0, 3);
        repeat (60) @(negedge clk);
        tone_ivl = IVL_W'(7); mode_sel = 1'b1;
        cur_req = "R8";
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_idle();

        // R2 / R10: interval 0 acts as 1, random strobes, abort mid-run
        cur_req = "R2"; tick_pat = 2;
        go(1'b0, 0);
        repeat (100) @(negedge clk);
        cur_req = "R10";
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        check("R10 busy after abort", longint'(busy), 0);
        repeat (5) @(negedge clk);

        // R10: abort with start while idle stays idle
        abort = 1'b1; start = 1'b1; @(negedge clk); abort = 1'b0; start = 1'b0;
        check("R10 abort+start idle", longint'(busy), 0);
        repeat (3) @(negedge clk);

        // R6: click mode, strobe every cycle, then random strobes
        cur_req = "R6"; tick_pat = 0;
        go(1'b1, 5);
        wait_idle();
        tick_pat = 2;
        go(1'b1, 2);
        wait_idle();
        check("R7 idle sample zero", longint'(sample_out), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule